// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block makes the system reset for a chip from two causes: a supply-good flag and an active-low manual-reset request. The supply-good flag is taken as already synchronized, and while it is low the reset stays asserted. The manual-reset request first passes through a two-flop synchronizer. It takes effect only when it stays low for a minimum qualification time, so short glitches are dropped.

Once both causes have cleared, the reset is held for a fixed release timeout before it deasserts. A new cause during that timeout clears the counter, and the full timeout then starts again. Both times are given in real units (microseconds for the timeout, nanoseconds for the qualification). They are turned into clock cycles from a clock-frequency parameter. The block drives an active-low reset and its active-high complement.

Top module: `supv_reset_gen`

## Requirements
- R1: While `supply_ok_i` is 0, `sys_rst_n_o` is 0 from the first clock edge after `supply_ok_i` is seen low.
- R2: With no manual reset active, `sys_rst_n_o` goes to 1 on the T-th clock edge after `supply_ok_i` returns to 1, where T = TIMEOUT_US*CLK_HZ/1e6 (at least 1).
- R3: A low on `supply_ok_i` during a running timeout, even for one cycle, restarts the full T-cycle timeout from its return to 1.
- R4: When `mr_n_i` stays low for Q or more cycles after the two-flop synchronizer, `sys_rst_n_o` goes to 0. Q = ceil(QUAL_NS*CLK_HZ/1e9), at least 1.
- R5: A low on `mr_n_i` that is shorter than Q cycles has no effect on `sys_rst_n_o`.
- R6: After a qualified manual reset is released, `sys_rst_n_o` stays 0 for T cycles plus the synchronizer and qualifier latency (3 cycles), then goes to 1.
- R7: `sys_rst_o` is always the exact complement of `sys_rst_n_o`.
- R8: While `rst_n` is 0, `sys_rst_n_o` is 0, the release counter is 0 and the manual-reset path reads as released.
- R9: The release counter saturates at T and never wraps. It is cleared while either cause is active, so the reset stays released with no cause present for any length of time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low power-on initialization, released synchronously |
| supply_ok_i | input | 1 | Synchronized supply-good flag, 1 = supply above threshold |
| mr_n_i | input | 1 | Asynchronous active-low manual-reset request |
| sys_rst_n_o | output | 1 | Active-low system reset |
| sys_rst_o | output | 1 | Active-high system reset, complement of `sys_rst_n_o` |

## Verification
The bench targets a supply drop in the middle of a running timeout. A design that only paused its counter, or ignored the drop, would release the reset early, well before the full T cycles. It drives manual-reset lows just under and just over Q. A qualifier with an off-by-a-few count would then either pass a glitch or swallow a valid press. It also holds the released state for several timeouts, which catches a counter that wraps and pulses the reset again. Random episodes of supply drops and manual presses check the release edge against a window around the expected cycle.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Convert a time amount (in 1/units_per_s seconds) to clock cycles.
  function automatic longint unsigned time_to_cycles(
    input longint unsigned amount,
    input longint unsigned clk_hz,
    input longint unsigned units_per_s,
    input bit              round_up
  );
    longint unsigned prod;
    prod = amount * clk_hz;
    if (round_up) return (prod + units_per_s - 1) / units_per_s;
    else          return prod / units_per_s;
  endfunction

  // Clamp a cycle count so every counter has at least one step.
  function automatic int unsigned at_least_one(input longint unsigned v);
    return (v < 1) ? 1 : int'(v);
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/supv_mr_qual.sv
module supv_mr_qual #(
  parameter int unsigned QCYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_s_i,
  output logic mr_act_o
);

  localparam int unsigned   QW   = (QCYC < 2) ? 1 : $clog2(QCYC + 1);
  localparam logic [QW-1:0] LAST = QW'(QCYC - 1);

  logic [QW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          act_q, act_d;

  always_comb begin
    if (mr_n_s_i) begin
      cnt_d  = '0;
      act_d  = 1'b0;
      cnt_en = (cnt_q != '0);
    end else begin
      act_d  = act_q | (cnt_q == LAST);
      cnt_d  = (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
      cnt_en = (cnt_q != LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign mr_act_o = act_q;

endmodule

// File: rtl/supv_release_timer.sv
module supv_release_timer #(
  parameter int unsigned TCYC = 1,
  parameter int unsigned CW   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cause_i,
  output logic          rel_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] FULL = CW'(TCYC);
  localparam logic [CW-1:0] NEAR = CW'(TCYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          rel_q, rel_d;

  always_comb begin
    if (cause_i) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
      rel_d  = 1'b0;
    end else begin
      cnt_d  = (cnt_q == FULL) ? FULL : cnt_q + 1'b1;
      cnt_en = (cnt_q != FULL);
      rel_d  = (cnt_q >= NEAR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  assign rel_o = rel_q;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned TIMEOUT_US = 200_000,
  parameter int unsigned QUAL_NS    = 150,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic mr_n_i,
  output logic sys_rst_n_o,
  output logic sys_rst_o
);

  import supv_pkg::*;

  localparam int unsigned TMO_CYC  = at_least_one(time_to_cycles(
                                       TIMEOUT_US, CLK_HZ, 64'd1_000_000, 1'b0));
  localparam int unsigned QUAL_CYC = at_least_one(time_to_cycles(
                                       QUAL_NS, CLK_HZ, 64'd1_000_000_000, 1'b1));
  localparam int unsigned CW       = (TMO_CYC < 2) ? 1 : $clog2(TMO_CYC + 1);

  logic          mr_n_s;
  logic          mr_act;
  logic          cause;
  logic          rel;
  logic [CW-1:0] tmr_cnt;

  supv_sync #(
    .STAGES  (SYNC_STG),
    .RST_VAL (1'b1)
  ) u_mr_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (mr_n_i),
    .q_o   (mr_n_s)
  );

  supv_mr_qual #(
    .QCYC (QUAL_CYC)
  ) u_mr_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .mr_n_s_i (mr_n_s),
    .mr_act_o (mr_act)
  );

  always_comb begin
    cause = ~supply_ok_i | mr_act;
  end

  supv_release_timer #(
    .TCYC (TMO_CYC),
    .CW   (CW)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cause_i (cause),
    .rel_o   (rel),
    .cnt_o   (tmr_cnt)
  );

  assign sys_rst_n_o = rel;
  assign sys_rst_o   = ~rel;

endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
  parameter int unsigned TMO_CYC = 1,
  parameter int unsigned CW      = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok_i,
  input logic          sys_rst_n_o,
  input logic          sys_rst_o,
  input logic          mr_act,
  input logic [CW-1:0] tmr_cnt
);

  // R1: a low supply flag forces reset on the next edge
  a_r1_supply_low_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> !sys_rst_n_o);

  // R3: a low supply flag clears the release count
  a_r3_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> (tmr_cnt == '0));

  // R2: release happens exactly as the count reaches the timeout
  a_r2_release_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n_o) |-> (tmr_cnt == CW'(TMO_CYC)));

  // R4: a qualified manual reset forces reset on the next edge
  a_r4_manual_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    mr_act |=> !sys_rst_n_o);

  // R7: the two reset outputs are complements
  a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o != sys_rst_n_o);

  // R9: the counter never passes the timeout
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_cnt <= CW'(TMO_CYC));

  // R8: while initialization is held, reset is asserted
  always_comb begin
    if (!rst_n) begin
      a_r8_init_asserted: assert (!sys_rst_n_o && tmr_cnt == '0);
    end
  end

endmodule

bind supv_reset_gen supv_reset_gen_chk #(
  .TMO_CYC (TMO_CYC),
  .CW      (CW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_ok_i (supply_ok_i),
  .sys_rst_n_o (sys_rst_n_o),
  .sys_rst_o   (sys_rst_o),
  .mr_act      (mr_act),
  .tmr_cnt     (tmr_cnt)
);

// File: tb/supv_reset_gen_bench.sv
`timescale 1ns/1ps
module supv_reset_gen_bench;

  localparam int unsigned CLK_HZ     = 250_000_000;
  localparam int unsigned TIMEOUT_US = 2;
  localparam int unsigned QUAL_NS    = 150;

  // Expected constants computed from the requirements
  localparam int T      = TIMEOUT_US * (CLK_HZ / 1_000_000);             // 500
  localparam int Q      = (QUAL_NS * (CLK_HZ / 1_000_000) + 999) / 1000; // 38
  localparam int MR_LAT = 3;
  localparam int TOL    = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok_i;
  logic mr_n_i;
  logic sys_rst_n_o;
  logic sys_rst_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  supv_reset_gen #(
    .CLK_HZ     (CLK_HZ),
    .TIMEOUT_US (TIMEOUT_US),
    .QUAL_NS    (QUAL_NS)
  ) u_supv_reset_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok_i (supply_ok_i),
    .mr_n_i      (mr_n_i),
    .sys_rst_n_o (sys_rst_n_o),
    .sys_rst_o   (sys_rst_o)
  );

  function automatic int release_delay(input bit from_manual);
    return T + (from_manual ? MR_LAT : 0);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_rst(input string req, input logic exp_n);
    checks++;
    if (sys_rst_n_o !== exp_n || sys_rst_o !== ~exp_n) begin
      errors++;
      $display("FAIL %s: rst_n=%b rst=%b expected rst_n=%b rst=%b",
               req, sys_rst_n_o, sys_rst_o, exp_n, ~exp_n);
    end
  endtask

  // Check the release edge lands inside a window around the expected cycle.
  task automatic check_release(input string req, input int delay);
    tick(delay - TOL);
    check_rst(req, 1'b0);
    tick(2 * TOL);
    check_rst(req, 1'b1);
  endtask

  task automatic hold_high(input string req, input int n);
    bit bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (sys_rst_n_o !== 1'b1 || sys_rst_o !== 1'b0) bad = 1'b1;
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: reset pulsed during hold, rst_n=%b expected 1", req, sys_rst_n_o);
    end
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 1'b0;
    supply_ok_i = 1'b0;
    mr_n_i = 1'b1;
    tick(4);
    check_rst("R8 init", 1'b0);
    supply_ok_i = 1'b1;
    tick(3);
    check_rst("R8 init with good supply", 1'b0);
    supply_ok_i = 1'b0;
    rst_n = 1'b1;
    tick(20);
    check_rst("R1 supply low held", 1'b0);

    // R2: release after T
    supply_ok_i = 1'b1;
    check_release("R2 supply release", release_delay(1'b0));
    // R9: stays released, no wrap
    hold_high("R9 saturate", 3 * T);

    // R1: one-cycle drop asserts
    supply_ok_i = 1'b0;
    tick(1);
    supply_ok_i = 1'b1;
    tick(1);
    check_rst("R1 short drop", 1'b0);
    check_release("R1 recover", release_delay(1'b0) - 1);

    // R3: drop mid timeout restarts full count
    supply_ok_i = 1'b0;
    tick(3);
    supply_ok_i = 1'b1;
    tick(T / 2);
    supply_ok_i = 1'b0;
    tick(2);
    supply_ok_i = 1'b1;
    tick(T / 2 + TOL);
    check_rst("R3 not released early", 1'b0);
    check_release("R3 restart", release_delay(1'b0) - T / 2 - TOL);

    // R4: long manual press
    mr_n_i = 1'b0;
    tick(Q + 8);
    check_rst("R4 manual asserts", 1'b0);
    mr_n_i = 1'b1;
    check_release("R6 manual release", release_delay(1'b1));

    // R5: short press ignored
    mr_n_i = 1'b0;
    tick(Q - 5);
    mr_n_i = 1'b1;
    hold_high("R5 short press ignored", Q + 10);

    // Random episodes
    for (int ep = 0; ep < 16; ep++) begin
      int kind;
      int len;
      kind = int'($urandom_range(2, 0));
      if (kind == 0) begin
        len = int'($urandom_range(40, 1));
        supply_ok_i = 1'b0;
        tick(len);
        supply_ok_i = 1'b1;
        check_rst("R1 random drop", 1'b0);
        check_release("R2 random drop", release_delay(1'b0));
      end else if (kind == 1) begin
        len = int'($urandom_range(Q + 60, Q + 3));
        mr_n_i = 1'b0;
        tick(len);
        check_rst("R4 random press", 1'b0);
        mr_n_i = 1'b1;
        check_release("R6 random press", release_delay(1'b1));
      end else begin
        len = int'($urandom_range(Q - 4, 1));
        mr_n_i = 1'b0;
        tick(len);
        mr_n_i = 1'b1;
        hold_high("R5 random glitch", Q + 6);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule